// File: doc/BRIEF.md
# Processor Exception Vector Selector

This block sits beside the execute stage of a simple in-order core and looks at each cycle's status: instruction completion, opcode class flags, a hardware breakpoint trigger, the pending interrupt level and a format-error request from the return-from-exception logic. From these it picks at most one exception to raise. It reports the vector number and a one-cycle start pulse to the exception sequencer, which builds the stack frame and fetches the handler address.

The trace exception depends on the status register's trace bit and is raised on instruction completion. A STOP completion is the one case that raises no trace. Instead the selector parks in a wait state until an interrupt above the current mask is pending, and then starts that interrupt. A breakpoint gets a fixed vector that is worked out inside the block, with no acknowledge cycle. Exceptions never nest. While the sequencer is working, the selector ignores every request until the sequencer signals done. A trace that coincides with another exception is dropped, and handler software must inspect the stacked trace bit instead.

Top module: `exc_vector_select`

## Requirements
- R1: After reset `exc_start_o`, `busy_o` and `halted_o` are 0 and `exc_vector_o` is 0.
- R2: A breakpoint trigger starts an exception with vector 12. It wins over every other request in the same cycle.
- R3: A format-error request starts vector 14. It wins over privilege, interrupt and trace.
- R4: A completed instruction flagged privileged while status bit 13 is 0 (user mode) starts vector 8. In supervisor mode (bit 13 = 1) it raises nothing.
- R5: An interrupt level L on `irq_level_i` is accepted when L is greater than the mask in status bits 10:8, or when L is 7. Level 0 means no request. An accepted interrupt starts vector 24 + L.
- R6: With status bit 15 = 1, a completed instruction starts vector 9 (trace). Trace has the lowest priority, and no trace is raised when another exception is taken in that cycle.
- R7: A completed STOP instruction raises no trace. It sets `halted_o`, and the block stays halted while no accepted interrupt is pending. An accepted interrupt then starts vector 24 + L and clears `halted_o`.
- R8: `exc_start_o` is registered and rises in the cycle after the request. It is high for exactly one cycle, and `exc_vector_o` is valid with it.
- R9: From the start pulse until `seq_done_i` is seen, `busy_o` is 1 and all requests are ignored. The cycle after `seq_done_i`, `busy_o` is 0 and new requests are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sr_i | input | 16 | Current status register (trace bit 15, supervisor bit 13, mask 10:8) |
| instr_done_i | input | 1 | Instruction completes this cycle |
| priv_op_i | input | 1 | Completing instruction is supervisor-only |
| stop_op_i | input | 1 | Completing instruction is STOP |
| brkpt_i | input | 1 | Hardware breakpoint trigger |
| irq_level_i | input | 3 | Pending interrupt level, 0 = none |
| fmt_err_i | input | 1 | Format error request from the return sequencer |
| seq_done_i | input | 1 | Exception sequencer finished |
| exc_start_o | output | 1 | One-cycle exception start pulse |
| exc_vector_o | output | 8 | Selected vector number |
| busy_o | output | 1 | Exception in progress, requests ignored |
| halted_o | output | 1 | Waiting after STOP |

## Verification
The bench uses the default parameters: a 16-bit status register, 3-bit interrupt levels and 8-bit vectors. With these widths every level from 0 to 7 and every mask value can be driven. That covers the level-7 override against mask 7 and the highest autovector, 31. Priority is tested by raising several requests in the same cycle and checking that only the winner's vector appears. The STOP wait is held across several cycles of masked interrupts before an accepted level releases it.

// File: rtl/exc_vector_select.sv
module exc_vector_select #(
  parameter int SR_W       = 16,
  parameter int LVL_W      = 3,
  parameter int VEC_W      = 8,
  parameter int TRACE_BIT  = 15,
  parameter int SUPER_BIT  = 13,
  parameter int MASK_LSB   = 8,
  parameter int VEC_PRIV   = 8,
  parameter int VEC_TRACE  = 9,
  parameter int VEC_BRK    = 12,
  parameter int VEC_FMT    = 14,
  parameter int VEC_AUTO   = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SR_W-1:0]  sr_i,
  input  logic             instr_done_i,
  input  logic             priv_op_i,
  input  logic             stop_op_i,
  input  logic             brkpt_i,
  input  logic [LVL_W-1:0] irq_level_i,
  input  logic             fmt_err_i,
  input  logic             seq_done_i,
  output logic             exc_start_o,
  output logic [VEC_W-1:0] exc_vector_o,
  output logic             busy_o,
  output logic             halted_o
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_BUSY} state_t;
  state_t state;

  wire [LVL_W-1:0] mask      = sr_i[MASK_LSB +: LVL_W];
  wire             irq_ok    = (irq_level_i != '0) &&
                               ((irq_level_i > mask) || (irq_level_i == '1));
  wire             priv_hit  = instr_done_i & priv_op_i & ~sr_i[SUPER_BIT];
  wire             trace_hit = instr_done_i & sr_i[TRACE_BIT] & ~stop_op_i;
  wire             stop_hit  = instr_done_i & stop_op_i;
  wire [VEC_W-1:0] irq_vec   = VEC_W'(VEC_AUTO) + VEC_W'(irq_level_i);

  logic             take;
  logic [VEC_W-1:0] vec;

  always_comb begin
    take = 1'b0;
    vec  = '0;
    if (state == S_IDLE) begin
      take = 1'b1;
      if (brkpt_i)        vec = VEC_W'(VEC_BRK);
      else if (fmt_err_i) vec = VEC_W'(VEC_FMT);
      else if (priv_hit)  vec = VEC_W'(VEC_PRIV);
      else if (irq_ok)    vec = irq_vec;
      else if (trace_hit) vec = VEC_W'(VEC_TRACE);
      else                take = 1'b0;
    end else if (state == S_WAIT && irq_ok) begin
      take = 1'b1;
      vec  = irq_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      exc_start_o  <= 1'b0;
      exc_vector_o <= '0;
    end else begin
      exc_start_o <= take;
      if (take) begin
        exc_vector_o <= vec;
        state        <= S_BUSY;
      end else if (state == S_IDLE && stop_hit) begin
        state <= S_WAIT;
      end else if (state == S_BUSY && seq_done_i) begin
        state <= S_IDLE;
      end
    end
  end

  assign busy_o   = (state == S_BUSY);
  assign halted_o = (state == S_WAIT);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    exc_start_o |=> !exc_start_o);

  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !seq_done_i |=> busy_o && !exc_start_o);

  a_r2_brk_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !halted_o && brkpt_i |=> exc_start_o && exc_vector_o == VEC_W'(VEC_BRK));

  a_r7_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o && !irq_ok |=> halted_o && !exc_start_o);

  a_r4_super_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !halted_o && instr_done_i && priv_op_i && sr_i[SUPER_BIT] &&
    !sr_i[TRACE_BIT] && !stop_op_i && !brkpt_i && !fmt_err_i && !irq_ok
    |=> !exc_start_o);

endmodule

// File: tb/exc_vector_select_test.sv
`timescale 1ns/1ps
module exc_vector_select_test;
  logic clk = 0, rst_n = 0;
  logic [15:0] sr;
  logic done, priv, stp, brk, fmt, sdone;
  logic [2:0] lvl;
  logic start, busy, halted;
  logic [7:0] vec;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  exc_vector_select uut (
    .clk(clk), .rst_n(rst_n), .sr_i(sr), .instr_done_i(done), .priv_op_i(priv),
    .stop_op_i(stp), .brkpt_i(brk), .irq_level_i(lvl), .fmt_err_i(fmt),
    .seq_done_i(sdone), .exc_start_o(start), .exc_vector_o(vec),
    .busy_o(busy), .halted_o(halted));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear();
    done = 0; priv = 0; stp = 0; brk = 0; fmt = 0; sdone = 0; lvl = 0;
    sr = 16'h2000;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect_exc(input string req, input int v);
    tick();
    chk(start === 1'b1, req, start, 1);
    chk(vec == v[7:0], req, vec, v);
    @(negedge clk); clear();
    tick();
    chk(start === 1'b0, {req, " R8 pulse"}, start, 0);
    @(negedge clk); sdone = 1;
    tick();
    chk(busy === 1'b0, {req, " R9 release"}, busy, 0);
    @(negedge clk); sdone = 0;
  endtask

  task automatic expect_none(input string req);
    tick();
    chk(start === 1'b0, req, start, 0);
    @(negedge clk); clear();
  endtask

  task automatic t_reset();
    chk(start === 0 && busy === 0 && halted === 0, "R1 flags", {start, busy, halted}, 0);
    chk(vec === 8'd0, "R1 vector", vec, 0);
  endtask

  task automatic t_brk();
    @(negedge clk); brk = 1; fmt = 1; done = 1; priv = 1; sr = 16'h8000; lvl = 7;
    expect_exc("R2 breakpoint wins", 12);
  endtask

  task automatic t_fmt();
    @(negedge clk); fmt = 1; done = 1; priv = 1; sr = 16'h8000; lvl = 5;
    expect_exc("R3 format error", 14);
  endtask

  task automatic t_priv();
    @(negedge clk); done = 1; priv = 1; sr = 16'h0000;
    expect_exc("R4 user privileged", 8);
    @(negedge clk); done = 1; priv = 1; sr = 16'h2000;
    expect_none("R4 supervisor no exception");
  endtask

  task automatic t_irq();
    @(negedge clk); sr = 16'h2300; lvl = 3;
    expect_none("R5 level equal to mask");
    @(negedge clk); sr = 16'h2300; lvl = 4;
    expect_exc("R5 level above mask", 28);
    @(negedge clk); sr = 16'h2700; lvl = 7;
    expect_exc("R5 level 7 override", 31);
    @(negedge clk); sr = 16'h2000; lvl = 0;
    expect_none("R5 level 0 none");
  endtask

  task automatic t_trace();
    @(negedge clk); sr = 16'hA000; done = 1;
    expect_exc("R6 trace", 9);
    @(negedge clk); sr = 16'h8000; done = 1; priv = 1;
    expect_exc("R6 trace loses to privilege", 8);
    @(negedge clk); sr = 16'hA000; done = 1; lvl = 2;
    expect_exc("R6 trace loses to interrupt", 26);
    @(negedge clk); sr = 16'hA000; done = 0;
    expect_none("R6 no trace without completion");
  endtask

  task automatic t_stop();
    @(negedge clk); sr = 16'hA500; done = 1; stp = 1;
    tick();
    chk(start === 1'b0, "R7 STOP no trace", start, 0);
    chk(halted === 1'b1, "R7 halted", halted, 1);
    @(negedge clk); clear(); sr = 16'hA500;
    for (int i = 0; i < 4; i++) begin
      lvl = 3'(i + 2);
      tick();
      chk(start === 1'b0 && halted === 1'b1, "R7 masked wait", {start, halted}, 1);
      @(negedge clk);
    end
    lvl = 6; done = 1; sr = 16'hA500;
    tick();
    chk(start === 1'b1 && vec == 8'd30, "R7 wake vector", vec, 30);
    chk(halted === 1'b0, "R7 halted cleared", halted, 0);
    @(negedge clk); clear(); sdone = 1;
    tick();
    @(negedge clk); sdone = 0;
  endtask

  task automatic t_busy();
    @(negedge clk); done = 1; priv = 1; sr = 16'h0000;
    tick();
    chk(start === 1'b1 && busy === 1'b1, "R8 start and busy", {start, busy}, 3);
    @(negedge clk); clear(); brk = 1; fmt = 1; lvl = 7;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(start === 1'b0 && busy === 1'b1, "R9 ignored while busy", {start, busy}, 1);
      chk(vec == 8'd8, "R9 vector held", vec, 8);
      @(negedge clk);
    end
    clear(); sdone = 1;
    tick();
    chk(busy === 1'b0 && start === 1'b0, "R9 done releases", {busy, start}, 0);
    @(negedge clk); sdone = 0; brk = 1;
    expect_exc("R9 accepts after done", 12);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear();
    #1; t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_brk();
    t_fmt();
    t_priv();
    t_irq();
    t_trace();
    t_stop();
    t_busy();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule